// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, through a tri-state transceiver. Each direction has a storage register with its own capture clock. A rising edge of the A-to-B capture clock stores the A bus, and a rising edge of the B-to-A capture clock stores the B bus. An active-low output enable and a direction input decide which port, if either, the block drives. A per-direction source select decides whether the driven port carries live data from the opposite bus or the contents of that direction's register.

With the output enable high, both ports float and the block acts only as a pair of capture registers. With the enable low, exactly one port is driven and the other acts as an input. Data on that input port can be captured into either register, or into both. An active-low reset, asserted asynchronously and released in step with the capture clocks, keeps both ports at high impedance and clears both registers. Besides the two bus pins, each port brings out its driven value and its drive enable so that a bench can observe them.

Top module: `bidir_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_ab` (reset inactive), the A-to-B register takes the value then present on `a_bus`. The value is observable on `b_drv` when `oe_n`=0, `dir`=1, `sel_ab`=1.
- R2: On each rising edge of `clk_ba` (reset inactive), the B-to-A register takes the value then present on `b_bus`. The value is observable on `a_drv` when `oe_n`=0, `dir`=0, `sel_ba`=1.
- R3: With `oe_n`=1, `a_en`=0 and `b_en`=0 and both buses carry only what external drivers place on them.
- R4: Both registers still capture on their clock edges while `oe_n`=1.
- R5: With `oe_n`=0, `dir`=1 gives `b_en`=1 and `a_en`=0, and `dir`=0 gives `a_en`=1 and `b_en`=0.
- R6: When B is driven, `sel_ab`=0 puts the live `a_bus` value on `b_bus` and `sel_ab`=1 puts the A-to-B register on it.
- R7: When A is driven, `sel_ba`=0 puts the live `b_bus` value on `a_bus` and `sel_ba`=1 puts the B-to-A register on it.
- R8: While `rst_n`=0, `a_en`=`b_en`=0 whatever the controls are. Reset clears both registers to 0, which shows on the ports after release.
- R9: `a_en` and `b_en` are never 1 together.
- R10: An edge on one capture clock leaves the other direction's register unchanged.
- R11: While one port is driven, data on the other port can be captured into either register or both, including on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset; keeps ports undriven and clears registers |
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1 drives port B, 0 drives port A (when enabled) |
| sel_ab | input | 1 | Source for port B: 0 live A, 1 stored A-to-B value |
| sel_ba | input | 1 | Source for port A: 0 live B, 1 stored B-to-A value |
| a_bus | inout | 8 | Tri-state bus A |
| b_bus | inout | 8 | Tri-state bus B |
| a_drv | output | 8 | Value the block places on A when `a_en` is 1 |
| a_en | output | 1 | Drive enable of port A |
| b_drv | output | 8 | Value the block places on B when `b_en` is 1 |
| b_en | output | 1 | Drive enable of port B |

## Verification
The bench places capture edges inside isolation and then reads the stored values back through the driven port. A design that gated capture with the output enable would return stale data there. It captures on both clocks in the same cycle that one port drives the other live, so a design that loaded a register from its own output side, or from the wrong bus, would store the wrong byte. Single-clock captures catch a design that tied the two register clocks together, because the untouched register would change. Checks during reset, with random controls applied, catch any drive enable that leaks out before release.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Which port the transceiver is currently driving
  typedef enum logic [1:0] {
    PATH_OFF = 2'b00,
    PATH_A2B = 2'b01,
    PATH_B2A = 2'b10
  } path_e;

  // Direction slots used in the generate loop
  localparam int unsigned SLOT_A2B = 0;
  localparam int unsigned SLOT_B2A = 1;
  localparam int unsigned N_SLOTS  = 2;
endpackage

// File: rtl/xcvr_store_reg.sv
`timescale 1ns/1ps
module xcvr_store_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // The capture clock is the enable: every edge loads the bus value
  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/xcvr_path_ctrl.sv
`timescale 1ns/1ps
module xcvr_path_ctrl
  import xcvr_pkg::*;
(
  input  logic  rst_n,
  input  logic  oe_n,
  input  logic  dir,
  output path_e path,
  output logic  a_en,
  output logic  b_en
);
  always_comb begin
    if (!rst_n || oe_n) path = PATH_OFF;
    else if (dir)       path = PATH_A2B;
    else                path = PATH_B2A;
  end

  // Decoded from one enum, so the two enables can never both be set
  assign b_en = (path == PATH_A2B);
  assign a_en = (path == PATH_B2A);
endmodule

// File: rtl/xcvr_src_sel.sv
`timescale 1ns/1ps
module xcvr_src_sel #(
  parameter int unsigned W = 8
) (
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  always_comb begin
    if (use_stored) y = stored;
    else            y = live;
  end
endmodule

// File: rtl/bidir_xcvr_reg.sv
`timescale 1ns/1ps
module bidir_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  inout  wire  [W-1:0] a_bus,
  inout  wire  [W-1:0] b_bus,
  output logic [W-1:0] a_drv,
  output logic         a_en,
  output logic [W-1:0] b_drv,
  output logic         b_en
);
  path_e path;

  logic [N_SLOTS-1:0] slot_clk;
  logic [N_SLOTS-1:0] slot_sel;
  logic [W-1:0]       slot_src [N_SLOTS];
  logic [W-1:0]       slot_q   [N_SLOTS];
  logic [W-1:0]       slot_out [N_SLOTS];

  // Slot 0 carries A toward B, slot 1 carries B toward A
  assign slot_clk[SLOT_A2B] = clk_ab;
  assign slot_clk[SLOT_B2A] = clk_ba;
  assign slot_sel[SLOT_A2B] = sel_ab;
  assign slot_sel[SLOT_B2A] = sel_ba;
  assign slot_src[SLOT_A2B] = a_bus;
  assign slot_src[SLOT_B2A] = b_bus;

  xcvr_path_ctrl u_path (
    .rst_n (rst_n),
    .oe_n  (oe_n),
    .dir   (dir),
    .path  (path),
    .a_en  (a_en),
    .b_en  (b_en)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    xcvr_store_reg #(.W(W)) u_store (
      .clk   (slot_clk[s]),
      .rst_n (rst_n),
      .d     (slot_src[s]),
      .q     (slot_q[s])
    );

    xcvr_src_sel #(.W(W)) u_sel (
      .use_stored (slot_sel[s]),
      .live       (slot_src[s]),
      .stored     (slot_q[s]),
      .y          (slot_out[s])
    );
  end

  assign b_drv = slot_out[SLOT_A2B];
  assign a_drv = slot_out[SLOT_B2A];

  assign a_bus = a_en ? a_drv : {W{1'bz}};
  assign b_bus = b_en ? b_drv : {W{1'bz}};
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker #(
  parameter int unsigned W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] a_drv,
  input logic         a_en,
  input logic [W-1:0] b_drv,
  input logic         b_en
);
  p_iso_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (!a_en && !b_en));

  p_iso_ba_r3: assert property (@(posedge clk_ba) disable iff (!rst_n)
    oe_n |-> (!a_en && !b_en));

  p_dir_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !oe_n |-> (b_en == dir) && (a_en == !dir));

  p_excl_r9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !(a_en && b_en));

  p_hiz_reset_r8: assert property (@(posedge clk_ab)
    !rst_n |-> (!a_en && !b_en));

  // Stored value on B equals what A held at the previous A-to-B edge
  p_cap_ab_r1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir && sel_ab && $past(rst_n)) |-> (b_drv == $past(a_bus)));

  // Stored value on A equals what B held at the previous B-to-A edge
  p_cap_ba_r2: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir && sel_ba && $past(rst_n)) |-> (a_drv == $past(b_bus)));
endmodule

bind bidir_xcvr_reg xcvr_checker #(.W(W)) u_chk (
  .rst_n  (rst_n),
  .clk_ab (clk_ab),
  .clk_ba (clk_ba),
  .oe_n   (oe_n),
  .dir    (dir),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba),
  .a_bus  (a_bus),
  .b_bus  (b_bus),
  .a_drv  (a_drv),
  .a_en   (a_en),
  .b_drv  (b_drv),
  .b_en   (b_en)
);

// File: tb/test_bidir_xcvr_reg.sv
`timescale 1ns/1ps
module test_bidir_xcvr_reg;
  localparam int unsigned W = 8;
  localparam time TCK = 8ns;
  localparam int unsigned WD_CYCLES = 200000;

  logic clk;
  logic rst_n;
  logic cap_ab, cap_ba;
  logic oe_n, dir, sel_ab, sel_ba;
  logic tb_a_oe, tb_b_oe;
  logic [W-1:0] tb_a_val, tb_b_val;
  logic [W-1:0] m_ab, m_ba;
  logic done;
  int n_chk, n_fail;

  wire clk_ab = clk & cap_ab;
  wire clk_ba = clk & cap_ba;
  wire [W-1:0] a_bus, b_bus;
  logic [W-1:0] a_drv, b_drv;
  logic a_en, b_en;

  assign a_bus = tb_a_oe ? tb_a_val : {W{1'bz}};
  assign b_bus = tb_b_oe ? tb_b_val : {W{1'bz}};

  bidir_xcvr_reg #(.W(W)) i_bidir_xcvr_reg (
    .rst_n  (rst_n),
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_bus  (a_bus),
    .b_bus  (b_bus),
    .a_drv  (a_drv),
    .a_en   (a_en),
    .b_drv  (b_drv),
    .b_en   (b_en)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  function automatic logic [W-1:0] pick(input logic use_stored,
                                        input logic [W-1:0] live,
                                        input logic [W-1:0] stored);
    return use_stored ? stored : live;
  endfunction

  task automatic check(input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One bus cycle: apply at falling edge, check, then model the captures
  task automatic step(input logic oen, input logic d, input logic sab,
                      input logic sba, input logic cab, input logic cba,
                      input logic [W-1:0] av, input logic [W-1:0] bv,
                      input string note);
    logic e_aen, e_ben;
    logic [W-1:0] eff_a, eff_b;
    string etag;
    @(negedge clk);
    oe_n = oen; dir = d; sel_ab = sab; sel_ba = sba;
    cap_ab = cab; cap_ba = cba;
    e_aen = rst_n && !oen && !d;
    e_ben = rst_n && !oen && d;
    tb_a_oe = !e_aen; tb_a_val = av;
    tb_b_oe = !e_ben; tb_b_val = bv;
    eff_a = e_aen ? pick(sba, bv, m_ba) : av;
    eff_b = e_ben ? pick(sab, av, m_ab) : bv;
    #1ns;
    etag = !rst_n ? "R8" : (oen ? "R3" : "R5");
    check({note, " ", etag, " a_en"}, a_en, e_aen);
    check({note, " ", etag, " b_en"}, b_en, e_ben);
    check({note, " R9 both enables"}, a_en & b_en, 1'b0);
    if (e_ben) begin
      check({note, sab ? " R6 stored onto B" : " R6 live onto B"}, b_drv, eff_b);
      check({note, " R6 b_bus"}, b_bus, eff_b);
    end else begin
      check({note, " R3 B undriven"}, b_bus, bv);
    end
    if (e_aen) begin
      check({note, sba ? " R7 stored onto A" : " R7 live onto A"}, a_drv, eff_a);
      check({note, " R7 a_bus"}, a_bus, eff_a);
    end else begin
      check({note, " R3 A undriven"}, a_bus, av);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_ab = '0; m_ba = '0;
    end else begin
      if (cab) m_ab = eff_a;
      if (cba) m_ba = eff_b;
    end
  endtask

  initial begin
    #(TCK * WD_CYCLES);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    done = 1'b0; n_chk = 0; n_fail = 0;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; cap_ab = 0; cap_ba = 0;
    oe_n = 1; dir = 0; sel_ab = 0; sel_ba = 0;
    tb_a_oe = 1; tb_b_oe = 1; tb_a_val = '0; tb_b_val = '0;
    m_ab = '0; m_ba = '0;

    // R8: random controls and capture edges while in reset
    for (int i = 0; i < 8; i++)
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), W'($urandom), W'($urandom), "reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R8: registers cleared, seen through the stored paths
    step(0, 1, 1, 0, 0, 0, 8'h11, 8'h22, "R8 cleared A-to-B");
    step(0, 0, 0, 1, 0, 0, 8'h33, 8'h44, "R8 cleared B-to-A");

    // R4: capture while isolated, then read back (R1, R2)
    step(1, 0, 0, 0, 1, 1, 8'h5A, 8'hA5, "R4 isolated capture");
    step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R4 R1 readback");
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R4 R2 readback");

    // R10: only the A-to-B clock fires; B-to-A content must stay
    step(1, 0, 0, 0, 1, 0, 8'h3C, 8'h77, "R10 single edge");
    step(0, 0, 0, 1, 0, 0, 8'hFF, 8'hFF, "R10 other kept");
    step(0, 1, 1, 0, 0, 0, 8'hFF, 8'hFF, "R10 R1 new value");

    // R11: B driven live from A, both registers capture the same edge
    step(0, 1, 0, 0, 1, 1, 8'hC3, 8'h00, "R11 capture while driving");
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R11 R2 readback");
    step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R11 R1 readback");

    // All sixteen control combinations with both captures
    for (int i = 0; i < 16; i++) begin
      logic [3:0] c;
      c = 4'(i);
      step(c[3], c[2], c[1], c[0], 1, 1, W'($urandom), W'($urandom), "all modes");
    end

    // Random traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), W'($urandom), W'($urandom), "random");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule